// File: doc/BRIEF.md
# Power-Down Clock Sequencer

This block controls how a clock synthesizer enters and leaves its low-power states. It watches two active-low requests. The global request shuts down the whole synthesizer. The fixed-PLL request shuts down only the pair of fixed-frequency outputs. The block turns these requests into run enables for the output groups and into enables for the main VCO, the fixed VCO and the crystal oscillator.

The global request arrives asynchronously and passes through a synchronizer before it has any effect. A shutdown always follows the same order. The output groups are parked low on a falling edge of the internal CPU clock. The block then waits until the REF path confirms that it is low. After that it stops both VCOs, and one cycle later it stops the crystal. Waking runs the steps in reverse, with two settle counters. The crystal runs for a set number of cycles before the VCOs start. The VCOs run for a set number of cycles before any output is released.

The fixed-PLL request has its own smaller sequence. That sequence gates the fixed output pair and the fixed VCO, and the global state always overrides it.

Top module: `lp_clock_sequencer`

## Requirements
- R1: While reset is held, every output of the block is 0: all group run enables, both VCO enables and the crystal enable.
- R2: A wake begins on the third rising edge after the global request is released, counted from the OFF state. At that edge the crystal enable rises. The VCO enables rise XTAL_SETTLE cycles later. The CPU, PCI and REF run enables rise VCO_SETTLE cycles after that. The total wake latency is therefore 3+XTAL_SETTLE+VCO_SETTLE cycles.
- R3: The global request is synchronized through two stages. A CPU falling edge seen at the first or second rising edge after the request is asserted does not stop any output.
- R4: Once shutdown has started, the output groups are parked low only at a rising edge where the internal CPU clock input was 1 at the previous edge and is 0 now. While no such falling edge occurs, the outputs keep running.
- R5: After the groups are parked, the VCOs stay enabled for as long as `ref_low` is 0. They stop at the first rising edge at which `ref_low` is 1.
- R6: The crystal enable falls one cycle after the VCO enables fall. No VCO enable is ever high while the crystal enable is low.
- R7: While the global request is released, asserting only the fixed-PLL request has these effects. `fixout_run` falls at the third rising edge. `fixed_vco_en` falls one edge later. CPU, PCI, REF, the main VCO and the crystal keep running.
- R8: Releasing the fixed-PLL request raises `fixed_vco_en` at the third rising edge. `fixout_run` rises VCO_SETTLE cycles after that.
- R9: The global request overrides the fixed-PLL request. `fixout_run` is never high while `cpu_run` is low. `fixout_run` drops with the other groups on a global shutdown and returns with them on wake.
- R10: A shutdown that has begun is committed. If the global request is released before the CPU falling edge, the block still parks the outputs, stops the VCOs and the crystal, and passes through OFF before it wakes.
- R11: After a complete wake with both requests released, all run enables, both VCO enables and the crystal enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset; the block leaves reset in OFF |
| pd_req_n | input | 1 | Global power-down request, active low, asynchronous |
| fixpd_req_n | input | 1 | Fixed-PLL power-down request, active low |
| cpu_clk_int | input | 1 | Level of the internal CPU clock, sampled to find falling edges |
| ref_low | input | 1 | 1 when the REF output path is confirmed parked low |
| cpu_run | output | 1 | Run enable for the CPU output group |
| pci_run | output | 1 | Run enable for the PCI reference output |
| ref_run | output | 1 | Run enable for the REF outputs |
| fixout_run | output | 1 | Run enable for the fixed-frequency output pair |
| main_vco_en | output | 1 | Main VCO enable |
| fixed_vco_en | output | 1 | Fixed VCO enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
The assertions check the ordering rules on every cycle. Outputs never run without their VCO. No VCO runs without the crystal. A group only stops on a CPU falling edge. The VCOs only fall after REF has confirmed it is low. The crystal falls last. The fixed pair is never running while the CPU group is stopped. The wake latency never exceeds the two settle windows. Some properties concern exact timing or what happens without a stimulus, and only the bench scenarios can show them. These are the synchronizer delay, the exact edge on which each wake step occurs, a falling edge that is ignored during synchronization, a shutdown that is committed despite an early release, and the fixed-pair sequence running while the rest of the chip stays up.

// File: rtl/lp_clock_sequencer.sv
`timescale 1ns/1ps
module lp_clock_sequencer #(
  parameter int SYNC_STAGES = 2,
  parameter int XTAL_SETTLE = 40,
  parameter int VCO_SETTLE  = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req_n,
  input  logic fixpd_req_n,
  input  logic cpu_clk_int,
  input  logic ref_low,
  output logic cpu_run,
  output logic pci_run,
  output logic ref_run,
  output logic fixout_run,
  output logic main_vco_en,
  output logic fixed_vco_en,
  output logic xtal_en
);
  localparam int MAXW = (XTAL_SETTLE > VCO_SETTLE) ? XTAL_SETTLE : VCO_SETTLE;
  localparam int CW   = $clog2(MAXW + 1);

  typedef enum logic [2:0] {
    S_RUN, S_PARK, S_VCO_OFF, S_XTAL_OFF, S_OFF, S_WAKE_XTAL, S_WAKE_VCO
  } main_t;
  typedef enum logic [1:0] {F_ON, F_PARK, F_OFF, F_WARM} fix_t;

  logic [SYNC_STAGES-1:0] pd_sync, fpd_sync;
  logic   cpu_q, grp_on;
  main_t  st;
  fix_t   fst;
  logic [CW-1:0] cnt, fcnt;

  wire pd_on    = ~pd_sync[SYNC_STAGES-1];
  wire fpd_on   = ~fpd_sync[SYNC_STAGES-1];
  wire cpu_fall = cpu_q & ~cpu_clk_int;
  wire vco_live = (st == S_RUN) || (st == S_PARK) || (st == S_WAKE_VCO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_sync  <= '0;
      fpd_sync <= '1;
      cpu_q    <= 1'b0;
    end else begin
      pd_sync  <= {pd_sync[SYNC_STAGES-2:0], pd_req_n};
      fpd_sync <= {fpd_sync[SYNC_STAGES-2:0], fixpd_req_n};
      cpu_q    <= cpu_clk_int;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      grp_on <= 1'b0;
      cnt    <= '0;
    end else begin
      case (st)
        S_RUN:      if (pd_on) st <= S_PARK;
        S_PARK: begin
          if (cpu_fall) grp_on <= 1'b0;
          if (!grp_on && ref_low) st <= S_VCO_OFF;
        end
        S_VCO_OFF:  st <= S_XTAL_OFF;
        S_XTAL_OFF: st <= S_OFF;
        S_OFF:
          if (!pd_on) begin
            st  <= S_WAKE_XTAL;
            cnt <= '0;
          end
        S_WAKE_XTAL:
          if (cnt == CW'(XTAL_SETTLE - 1)) begin
            st  <= S_WAKE_VCO;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_WAKE_VCO:
          if (cnt == CW'(VCO_SETTLE - 1)) begin
            st     <= S_RUN;
            grp_on <= 1'b1;
          end else cnt <= cnt + 1'b1;
        default:    st <= S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst  <= F_WARM;
      fcnt <= '0;
    end else begin
      case (fst)
        F_ON:
          if (fpd_on) fst <= F_PARK;
          else if (!vco_live) begin
            fst  <= F_WARM;
            fcnt <= '0;
          end
        F_PARK: fst <= F_OFF;
        F_OFF:
          if (!fpd_on && vco_live) begin
            fst  <= F_WARM;
            fcnt <= '0;
          end
        F_WARM:
          if (fpd_on) fst <= F_OFF;
          else if (!vco_live) fcnt <= '0;
          else if (fcnt == CW'(VCO_SETTLE - 1)) fst <= F_ON;
          else fcnt <= fcnt + 1'b1;
        default: fst <= F_OFF;
      endcase
    end
  end

  assign cpu_run      = grp_on;
  assign pci_run      = grp_on;
  assign ref_run      = grp_on;
  assign fixout_run   = grp_on && (fst == F_ON);
  assign main_vco_en  = vco_live;
  assign fixed_vco_en = vco_live && (fst != F_OFF);
  assign xtal_en      = (st != S_XTAL_OFF) && (st != S_OFF);
endmodule

module lp_clock_sequencer_chk #(
  parameter int XTAL_SETTLE = 40,
  parameter int VCO_SETTLE  = 24
) (
  input logic clk,
  input logic rst_n,
  input logic cpu_clk_int,
  input logic ref_low,
  input logic cpu_run,
  input logic pci_run,
  input logic ref_run,
  input logic fixout_run,
  input logic main_vco_en,
  input logic fixed_vco_en,
  input logic xtal_en
);
  logic xtal_q, waking;
  int   wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xtal_q <= 1'b0;
      waking <= 1'b0;
      wcnt   <= 0;
    end else begin
      xtal_q <= xtal_en;
      if (!xtal_en) begin
        waking <= 1'b0;
        wcnt   <= 0;
      end else if (!xtal_q) begin
        waking <= 1'b1;
        wcnt   <= 1;
      end else if (cpu_run) waking <= 1'b0;
      else if (waking) wcnt <= wcnt + 1;
    end
  end

  assert_park_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_run) |-> ($past(cpu_clk_int, 2) && !$past(cpu_clk_int)));
  assert_ref_before_vco_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(main_vco_en) |-> (!cpu_run && !pci_run && !ref_run && $past(ref_low)));
  assert_xtal_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xtal_en) |-> (!main_vco_en && !fixed_vco_en));
  assert_vco_needs_xtal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (main_vco_en || fixed_vco_en) |-> xtal_en);
  assert_outputs_need_vco_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run |-> (main_vco_en && xtal_en));
  assert_wake_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    waking |-> (wcnt <= XTAL_SETTLE + VCO_SETTLE));
  assert_fix_dominated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fixout_run |-> cpu_run);
  assert_fix_needs_vco_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fixout_run |-> fixed_vco_en);
endmodule

bind lp_clock_sequencer lp_clock_sequencer_chk #(
  .XTAL_SETTLE(XTAL_SETTLE), .VCO_SETTLE(VCO_SETTLE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_clk_int(cpu_clk_int), .ref_low(ref_low),
  .cpu_run(cpu_run), .pci_run(pci_run), .ref_run(ref_run),
  .fixout_run(fixout_run), .main_vco_en(main_vco_en),
  .fixed_vco_en(fixed_vco_en), .xtal_en(xtal_en)
);

// File: tb/lp_clock_sequencer_test.sv
`timescale 1ns/1ps
module lp_clock_sequencer_test;
  localparam int XS = 40;
  localparam int VS = 24;
  localparam int WAKE = 3 + XS + VS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pd_req_n = 1'b1, fixpd_req_n = 1'b1, cpu_clk_int = 1'b1, ref_low = 1'b1;
  logic cpu_run, pci_run, ref_run, fixout_run, main_vco_en, fixed_vco_en, xtal_en;
  int n_chk = 0, n_bad = 0, cycles = 0;

  always #10 clk = ~clk;

  lp_clock_sequencer #(.XTAL_SETTLE(XS), .VCO_SETTLE(VS)) uut (
    .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .fixpd_req_n(fixpd_req_n),
    .cpu_clk_int(cpu_clk_int), .ref_low(ref_low), .cpu_run(cpu_run),
    .pci_run(pci_run), .ref_run(ref_run), .fixout_run(fixout_run),
    .main_vco_en(main_vco_en), .fixed_vco_en(fixed_vco_en), .xtal_en(xtal_en));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wake_count(output int n);
    n = 0;
    while (!cpu_run && n < 1000) begin
      cyc(1);
      n++;
    end
  endtask

  task automatic t_reset;
    cyc(3);
    chk("R1 all outputs", {cpu_run, pci_run, ref_run, fixout_run,
                           main_vco_en, fixed_vco_en, xtal_en}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_powerup;
    cyc(2);
    chk("R2 xtal still off", xtal_en, 0);
    cyc(1);
    chk("R2 xtal on", xtal_en, 1);
    chk("R2 vco off during xtal settle", main_vco_en, 0);
    cyc(XS - 1);
    chk("R2 vco waits xtal settle", main_vco_en, 0);
    cyc(1);
    chk("R2 vcos on", {main_vco_en, fixed_vco_en}, 3);
    cyc(VS - 1);
    chk("R2 outputs wait vco settle", cpu_run, 0);
    cyc(1);
    chk("R11 all running", {cpu_run, pci_run, ref_run, fixout_run,
                            main_vco_en, fixed_vco_en, xtal_en}, 7'h7f);
  endtask

  task automatic t_sync_and_fall;
    int n;
    cpu_clk_int = 1'b1;
    pd_req_n = 1'b0;
    cyc(1);
    cpu_clk_int = 1'b0;
    cyc(1);
    chk("R3 fall during sync ignored", cpu_run, 1);
    cyc(1);
    chk("R3 still running after sync", cpu_run, 1);
    cyc(3);
    chk("R4 no fall keeps running", {cpu_run, pci_run, ref_run}, 7);
    cpu_clk_int = 1'b1;
    cyc(1);
    chk("R4 rising edge does not stop", cpu_run, 1);
    cpu_clk_int = 1'b0;
    cyc(1);
    chk("R4 parked on fall", {cpu_run, pci_run, ref_run, fixout_run}, 0);
    chk("R4 vco still on at park", main_vco_en, 1);
    cyc(1);
    chk("R6 vcos off", {main_vco_en, fixed_vco_en}, 0);
    chk("R6 xtal on with vcos off", xtal_en, 1);
    cyc(1);
    chk("R6 xtal off", xtal_en, 0);
    pd_req_n = 1'b1;
    cpu_clk_int = 1'b1;
    wake_count(n);
    chk("R2 wake latency", n, WAKE);
  endtask

  task automatic t_ref_wait;
    int n;
    ref_low = 1'b0;
    pd_req_n = 1'b0;
    cyc(4);
    cpu_clk_int = 1'b0;
    cyc(1);
    chk("R5 parked", cpu_run, 0);
    cyc(5);
    chk("R5 vco held until ref low", main_vco_en, 1);
    chk("R5 xtal held", xtal_en, 1);
    ref_low = 1'b1;
    cyc(1);
    chk("R5 vco off after ref low", main_vco_en, 0);
    cyc(1);
    pd_req_n = 1'b1;
    cpu_clk_int = 1'b1;
    wake_count(n);
    chk("R5 wake after ref wait", n, WAKE);
  endtask

  task automatic t_fixed_only;
    fixpd_req_n = 1'b0;
    cyc(2);
    chk("R7 fixed pair during sync", fixout_run, 1);
    cyc(1);
    chk("R7 fixed pair off", fixout_run, 0);
    chk("R7 fixed vco still on", fixed_vco_en, 1);
    cyc(1);
    chk("R7 fixed vco off", fixed_vco_en, 0);
    cyc(10);
    chk("R7 others run", {cpu_run, pci_run, ref_run, main_vco_en, xtal_en}, 5'h1f);
    fixpd_req_n = 1'b1;
    cyc(2);
    chk("R8 fixed vco during sync", fixed_vco_en, 0);
    cyc(1);
    chk("R8 fixed vco on", fixed_vco_en, 1);
    chk("R8 fixed pair waits", fixout_run, 0);
    cyc(VS - 1);
    chk("R8 fixed pair before settle", fixout_run, 0);
    cyc(1);
    chk("R8 fixed pair on", fixout_run, 1);
  endtask

  task automatic t_dominance;
    int n;
    pd_req_n = 1'b0;
    cyc(3);
    chk("R9 fixed pair before park", fixout_run, 1);
    cpu_clk_int = 1'b0;
    cyc(1);
    chk("R9 fixed pair parked by global", fixout_run, 0);
    cyc(2);
    pd_req_n = 1'b1;
    cpu_clk_int = 1'b1;
    wake_count(n);
    chk("R9 wake latency", n, WAKE);
    chk("R9 fixed pair returns with group", fixout_run, 1);
  endtask

  task automatic t_commit;
    int n;
    pd_req_n = 1'b0;
    cyc(3);
    pd_req_n = 1'b1;
    cyc(4);
    chk("R10 waiting for fall", cpu_run, 1);
    cpu_clk_int = 1'b0;
    cyc(1);
    chk("R10 parked despite release", cpu_run, 0);
    cyc(2);
    chk("R10 xtal stopped", xtal_en, 0);
    cyc(1);
    chk("R10 passes OFF", xtal_en, 0);
    cyc(1);
    chk("R10 wake starts", {xtal_en, main_vco_en}, 2);
    cpu_clk_int = 1'b1;
    wake_count(n);
    chk("R10 rejoins run", n, XS + VS);
  endtask

  initial begin
    t_reset;
    t_powerup;
    t_sync_and_fall;
    t_ref_wait;
    t_fixed_only;
    t_dominance;
    t_commit;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule